// File: doc/BRIEF.md
# Conditional Branch Byte Decoder

This block takes an instruction stream one byte at a time and picks out conditional relative jumps. It accepts three forms: a two-byte short form whose opcode nibble is 7h, a near form that begins with the escape byte 0Fh, and a short form that tests the count register for zero instead of the flags. The block gathers the displacement bytes that follow the opcode, sign-extends the displacement to the instruction-pointer width and presents one decoded record. The record holds a condition number, a count-test flag, the displacement width code, the displacement, the total byte length and two error indications.

Two static inputs set the displacement size of the near form: the long (64-bit) mode flag and the operand-size flag. A lock prefix byte (F0h) may come before the opcode. The decoder accepts it, counts it in the length and marks the decoded jump as faulting. Any byte stream outside the supported set ends in a record marked unsupported. Each record is held until the consumer takes it. Input ready stays low for as long as a record is waiting.

Top module: `cbr_decoder`

## Requirements
- R1: A first byte 70h..7Fh produces a record with cond = low nibble of that byte, cntz = 0, wsel = 0 (one displacement byte) and length 2.
- R2: A first byte E3h produces a record with cntz = 1, cond = 0, wsel = 0 and length 2.
- R3: 0Fh followed by 80h..8Fh, with mode64 = 0 and opsize32 = 1, produces cond = low nibble of the second byte, wsel = 2 (four displacement bytes) and length 6.
- R4: The same near form with mode64 = 0 and opsize32 = 0 produces wsel = 1 (two displacement bytes) and length 4.
- R5: When mode64 = 1, the near form always uses wsel = 2, whatever opsize32 is. wsel = 1 never appears in long mode.
- R6: Displacement bytes are taken least-significant first. out_disp is the displacement sign-extended to IP_W bits.
- R7: A single F0h before a supported jump sets out_fault = 1 and adds one to the length. A second F0h in a row ends in an unsupported record.
- R8: A first byte outside {70h..7Fh, E3h, 0Fh, F0h}, or a byte after 0Fh outside 80h..8Fh, produces unsup = 1, fault = 0, cond = 0, wsel = 0, disp = 0 and length = bytes consumed.
- R9: While out_valid is high and out_ready is low, the record stays unchanged and in_ready is low. A byte offered during the stall is not taken.
- R10: A synchronous reset in the middle of an instruction discards the bytes collected so far. The next instruction decodes cleanly.
- R11: After reset, out_valid = 0 and in_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode64 | input | 1 | Long mode: near displacement is always 4 bytes |
| opsize32 | input | 1 | Operand size 32 (1) or 16 (0) outside long mode |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_cond | output | 4 | Condition number |
| out_cntz | output | 1 | Count-register-zero test instead of flags |
| out_wsel | output | 2 | Displacement width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| out_disp | output | IP_W | Sign-extended displacement |
| out_len | output | 4 | Total bytes consumed, prefix included |
| out_unsup | output | 1 | Unsupported byte sequence |
| out_fault | output | 1 | Lock prefix on a jump (invalid opcode) |

## Verification
A byte counts as taken at the rising edge where both in_valid and in_ready are high. The record becomes visible just after the edge that takes the last displacement byte, or the edge that takes the offending byte for an unsupported sequence. So out_valid is due one register stage after the final byte. The bench drives inputs on the falling edge and reads the record on the falling edge after that last byte, with no extra wait. It waits for in_ready before it offers each byte. In the stall test it reads the held record on several later falling edges to confirm nothing moved.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
    localparam int DISP_MAX_BYTES = 4;
    localparam int RAW_W          = DISP_MAX_BYTES * 8;
    localparam int IDX_W          = $clog2(DISP_MAX_BYTES);
    localparam int LEN_W          = 4;

    typedef enum logic [1:0] {ST_OP, ST_ESC, ST_DISP, ST_HOLD} st_e;

    typedef enum logic [2:0] {K_SHORT, K_CNTZ, K_ESC, K_LOCK, K_BAD} kind_e;

    typedef struct packed {
        st_e              st;
        logic             lock;
        logic [3:0]       cond;
        logic             cntz;
        logic             unsup;
        logic [1:0]       wsel;
        logic [IDX_W-1:0] idx;
        logic [RAW_W-1:0] raw;
        logic [LEN_W-1:0] len;
    } dec_s;
endpackage

// File: rtl/cbr_classify.sv
module cbr_classify
    import cbr_pkg::*;
(
    input  logic [7:0] byte_i,
    output kind_e      kind_o
);
    always_comb begin
        if (byte_i[7:4] == 4'h7)      kind_o = K_SHORT;
        else if (byte_i == 8'hE3)     kind_o = K_CNTZ;
        else if (byte_i == 8'h0F)     kind_o = K_ESC;
        else if (byte_i == 8'hF0)     kind_o = K_LOCK;
        else                          kind_o = K_BAD;
    end
endmodule

// File: rtl/cbr_sext.sv
module cbr_sext
    import cbr_pkg::*;
#(
    parameter int OUT_W = 64
) (
    input  logic [RAW_W-1:0] raw_i,
    input  logic [1:0]       wsel_i,
    output logic [OUT_W-1:0] disp_o
);
    always_comb begin
        case (wsel_i)
            2'd0:    disp_o = {{(OUT_W-8){raw_i[7]}},   raw_i[7:0]};
            2'd1:    disp_o = {{(OUT_W-16){raw_i[15]}}, raw_i[15:0]};
            default: disp_o = {{(OUT_W-32){raw_i[31]}}, raw_i[31:0]};
        endcase
    end
endmodule

// File: rtl/cbr_decoder.sv
module cbr_decoder
    import cbr_pkg::*;
#(
    parameter int IP_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode64,
    input  logic             opsize32,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [3:0]       out_cond,
    output logic             out_cntz,
    output logic [1:0]       out_wsel,
    output logic [IP_W-1:0]  out_disp,
    output logic [LEN_W-1:0] out_len,
    output logic             out_unsup,
    output logic             out_fault
);
    localparam dec_s IDLE_S = '{st: ST_OP, lock: 1'b0, cond: 4'd0, cntz: 1'b0,
                                unsup: 1'b0, wsel: 2'd0, idx: '0, raw: '0, len: '0};

    dec_s  dec_d, dec_q;
    kind_e kind;
    logic  take;
    logic [IDX_W-1:0] last_idx;

    cbr_classify u_cls (.byte_i(in_byte), .kind_o(kind));

    assign take = in_valid && in_ready;

    always_comb begin
        case (dec_q.wsel)
            2'd0:    last_idx = IDX_W'(0);
            2'd1:    last_idx = IDX_W'(1);
            default: last_idx = IDX_W'(DISP_MAX_BYTES - 1);
        endcase
    end

    always_comb begin
        dec_d = dec_q;
        case (dec_q.st)
            ST_OP: begin
                if (take) begin
                    dec_d.len = dec_q.len + 1'b1;
                    case (kind)
                        K_LOCK: begin
                            if (dec_q.lock) begin
                                dec_d.unsup = 1'b1;
                                dec_d.st    = ST_HOLD;
                            end else begin
                                dec_d.lock = 1'b1;
                            end
                        end
                        K_SHORT: begin
                            dec_d.cond = in_byte[3:0];
                            dec_d.wsel = 2'd0;
                            dec_d.st   = ST_DISP;
                        end
                        K_CNTZ: begin
                            dec_d.cntz = 1'b1;
                            dec_d.wsel = 2'd0;
                            dec_d.st   = ST_DISP;
                        end
                        K_ESC: begin
                            dec_d.st = ST_ESC;
                        end
                        default: begin
                            dec_d.unsup = 1'b1;
                            dec_d.st    = ST_HOLD;
                        end
                    endcase
                end
            end
            ST_ESC: begin
                if (take) begin
                    dec_d.len = dec_q.len + 1'b1;
                    if (in_byte[7:4] == 4'h8) begin
                        dec_d.cond = in_byte[3:0];
                        dec_d.wsel = (mode64 || opsize32) ? 2'd2 : 2'd1;
                        dec_d.st   = ST_DISP;
                    end else begin
                        dec_d.unsup = 1'b1;
                        dec_d.st    = ST_HOLD;
                    end
                end
            end
            ST_DISP: begin
                if (take) begin
                    dec_d.len = dec_q.len + 1'b1;
                    dec_d.raw[{dec_q.idx, 3'b000} +: 8] = in_byte;
                    if (dec_q.idx == last_idx) begin
                        dec_d.st = ST_HOLD;
                    end else begin
                        dec_d.idx = dec_q.idx + 1'b1;
                    end
                end
            end
            default: begin
                if (out_ready) begin
                    dec_d = IDLE_S;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= IDLE_S;
        else     dec_q <= dec_d;
    end

    cbr_sext #(.OUT_W(IP_W)) u_sext (
        .raw_i (dec_q.raw),
        .wsel_i(dec_q.wsel),
        .disp_o(out_disp)
    );

    assign in_ready  = (dec_q.st != ST_HOLD);
    assign out_valid = (dec_q.st == ST_HOLD);
    assign out_cond  = dec_q.cond;
    assign out_cntz  = dec_q.cntz;
    assign out_wsel  = dec_q.wsel;
    assign out_len   = dec_q.len;
    assign out_unsup = dec_q.unsup;
    assign out_fault = dec_q.lock && !dec_q.unsup;
endmodule

// File: rtl/cbr_decoder_chk.sv
module cbr_decoder_chk
    import cbr_pkg::*;
#(
    parameter int IP_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             mode64,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [3:0]       out_cond,
    input logic [1:0]       out_wsel,
    input logic [IP_W-1:0]  out_disp,
    input logic [LEN_W-1:0] out_len,
    input logic             out_unsup,
    input logic             out_fault
);
    a_r9_ready_low: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_disp)
            && $stable(out_len) && $stable(out_cond));

    a_r5_no_word_in_long: assert property (@(posedge clk) disable iff (rst)
        out_valid && mode64 && !out_unsup |-> out_wsel != 2'd1);

    a_r6_byte_sext: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_wsel == 2'd0 |->
            (out_disp[IP_W-1:7] == '0) || (out_disp[IP_W-1:7] == '1));

    a_r8_unsup_clean: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_unsup |-> out_disp == '0 && !out_fault && out_wsel == 2'd0);

    a_r1_short_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_unsup && out_wsel == 2'd0 |->
            out_len == (LEN_W'(2) + LEN_W'(out_fault)));
endmodule

bind cbr_decoder cbr_decoder_chk #(.IP_W(IP_W)) u_chk (
    .clk(clk), .rst(rst), .mode64(mode64), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_cond(out_cond),
    .out_wsel(out_wsel), .out_disp(out_disp), .out_len(out_len),
    .out_unsup(out_unsup), .out_fault(out_fault)
);

// File: tb/cbr_decoder_test.sv
module cbr_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode64 = 1'b0, opsize32 = 1'b1;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, out_valid, out_cntz, out_unsup, out_fault;
    logic [3:0]  out_cond, out_len;
    logic [1:0]  out_wsel;
    logic [63:0] out_disp;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    cbr_decoder #(.IP_W(64)) uut (
        .clk(clk), .rst(rst), .mode64(mode64), .opsize32(opsize32),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_cond(out_cond),
        .out_cntz(out_cntz), .out_wsel(out_wsel), .out_disp(out_disp),
        .out_len(out_len), .out_unsup(out_unsup), .out_fault(out_fault)
    );

    typedef struct packed {
        logic [55:0] bytes;
        logic [2:0]  nb;
        logic        m64;
        logic        o32;
        logic [3:0]  cond;
        logic        cntz;
        logic        unsup;
        logic        fault;
        logic [1:0]  wsel;
        logic [63:0] disp;
        logic [3:0]  len;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{56'h0574,           3'd2, 1'b0, 1'b1, 4'h4, 1'b0, 1'b0, 1'b0, 2'd0, 64'h5,                  4'd2}, // R1
        '{56'hFE7C,           3'd2, 1'b0, 1'b1, 4'hC, 1'b0, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFE, 4'd2}, // R1 R6
        '{56'h80E3,           3'd2, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 4'd2}, // R2
        '{56'h12345678850F,   3'd6, 1'b0, 1'b1, 4'h5, 1'b0, 1'b0, 1'b0, 2'd2, 64'h1234_5678,          4'd6}, // R3 R6
        '{56'h80008F0F,       3'd4, 1'b0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0, 2'd1, 64'hFFFF_FFFF_FFFF_8000, 4'd4}, // R4
        '{56'hFFFFFFFF800F,   3'd6, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 4'd6}, // R5
        '{56'h1077F0,         3'd3, 1'b0, 1'b1, 4'h7, 1'b0, 1'b0, 1'b1, 2'd0, 64'h10,                 4'd3}, // R7
        '{56'h90,             3'd1, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0,                  4'd1}, // R8
        '{56'h900F,           3'd2, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0,                  4'd2}, // R8
        '{56'hF0F0,           3'd2, 1'b0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0,                  4'd2}, // R7 R8
        '{56'h040302018A0FF0, 3'd7, 1'b1, 1'b1, 4'hA, 1'b0, 1'b0, 1'b1, 2'd2, 64'h0403_0201,          4'd7}  // R5 R7
    };

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Drive on the falling edge; the byte is taken at the next rising edge.
    task automatic send(input logic [7:0] b);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_rec(input string req, input vec_t v);
        chk(req, "out_valid", 64'(out_valid), 64'h1);
        chk(req, "cond",  64'(out_cond),  64'(v.cond));
        chk(req, "cntz",  64'(out_cntz),  64'(v.cntz));
        chk(req, "unsup", 64'(out_unsup), 64'(v.unsup));
        chk(req, "fault", 64'(out_fault), 64'(v.fault));
        chk(req, "wsel",  64'(out_wsel),  64'(v.wsel));
        chk(req, "disp",  out_disp,       v.disp);
        chk(req, "len",   64'(out_len),   64'(v.len));
    endtask

    task automatic consume();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11", "out_valid", 64'(out_valid), 64'h0);
        chk("R11", "in_ready",  64'(in_ready),  64'h1);

        for (int i = 0; i < 11; i++) begin
            v = VECS[i];
            mode64   = v.m64;
            opsize32 = v.o32;
            for (int k = 0; k < int'(v.nb); k++) send(v.bytes[k*8 +: 8]);
            // record is due right after the edge that took the final byte
            check_rec($sformatf("R1-vector%0d", i), v);
            consume();
        end

        // R9: stall holds the record and refuses a new byte
        mode64 = 1'b0; opsize32 = 1'b1;
        send(8'h74); send(8'hF6);
        in_valid = 1'b1; in_byte = 8'h90;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "out_valid held", 64'(out_valid), 64'h1);
            chk("R9", "in_ready low",   64'(in_ready),  64'h0);
            chk("R9", "disp held",      out_disp,       64'hFFFF_FFFF_FFFF_FFF6);
            chk("R9", "cond held",      64'(out_cond),  64'h4);
        end
        in_valid = 1'b0;
        consume();
        chk("R9", "released", 64'(out_valid), 64'h0);
        send(8'h75); send(8'h01);
        chk("R9", "next cond",  64'(out_cond),  64'h5);
        chk("R9", "next unsup", 64'(out_unsup), 64'h0);
        chk("R9", "next len",   64'(out_len),   64'h2);
        consume();

        // R10: reset in the middle of a near form
        send(8'h0F); send(8'h85); send(8'h12);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "out_valid after reset", 64'(out_valid), 64'h0);
        send(8'h74); send(8'h03);
        chk("R10", "cond", 64'(out_cond), 64'h4);
        chk("R10", "disp", out_disp,      64'h3);
        chk("R10", "len",  64'(out_len),  64'h2);
        consume();

        report();
    end
endmodule